// File: doc/BRIEF.md
# Superframe Multiplexer and Framer for a DMT Line Transmitter

This block builds the two transmit byte streams that feed a DMT line transmitter. Three byte sources arrive on valid/ready handshakes: a high-rate simplex channel, a low-rate control channel and a duplex channel. The duplex bytes are packed into a short fast-path frame. The simplex and control bytes are packed into a longer interleaved-path frame. The block adds each path's overhead bytes, so both paths emit one frame per frame slot and stay slot-aligned.

Frame slots are counted in a superframe of 68 data frames followed by one sync frame. The overhead byte of a few fixed slots carries a CRC value or indicator bits. These values are sampled by the block at the close of the previous superframe. Scrambling, the CRC computation, forward error correction and interleaving all sit downstream or upstream and are not part of this block.

Each frame slot lasts 52 byte positions, which is the length of an interleaved frame. A position is counted only when every byte needed at that position is available. The interleaved path emits one byte for every counted position. The fast path emits a byte only for the first seven positions of each slot.

Top module: `sf_framer`

## Requirements
- R1: After reset no output byte is produced and no channel is acknowledged until `sx_valid`, `ctl_valid` and `dx_valid` have been high together in one cycle. The first byte emitted after that is frame 0, position 0, with both start-of-frame and start-of-superframe markers high.
- R2: An interleaved frame is 52 bytes in this order: the overhead byte at position 0, 48 simplex bytes at positions 1 to 48, the control slot at position 49, then two idle bytes of 0x00 at positions 50 and 51. The overhead byte of an ordinary frame is 0xA5.
- R3: In even-numbered data frames the control slot carries the next control-channel byte. In odd-numbered frames it carries 0x00, and no control byte is acknowledged during that frame.
- R4: A fast frame is 7 bytes: the overhead byte, 5 duplex bytes, then one idle byte of 0x00. It is emitted in the same cycles as interleaved positions 0 to 6, and `fast_vld` is never high without `intl_vld`.
- R5: A superframe has 69 frame slots, numbered 0 to 68. Slot 68 is the sync frame: its payload and control positions carry 0x00, and it consumes no channel byte. After its last byte, framing restarts at frame 0.
- R6: The overhead byte of frame 0 carries the path's own CRC input, `crc_fast_in` or `crc_intl_in`. That value is captured in the cycle in which the last byte of the previous sync frame is produced. It is 0x00 in the first superframe after reset.
- R7: On both paths, the overhead bytes of frames 1, 34 and 35 carry `ind_in[7:0]`, `ind_in[15:8]` and `ind_in[23:16]` respectively. These are captured at the same moment as the CRC.
- R8: When a byte needed at the current position is not valid, neither path emits a byte in the following cycle and the position does not advance. A ready output is high only together with its valid and only for a byte actually consumed.
- R9: Each path's `*_sof` marks position 0 of every frame. Each path's `*_sosf` is high only on position 0 of frame 0, and it rises on both paths in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sx_data | input | 8 | Simplex channel byte |
| sx_valid | input | 1 | Simplex byte available |
| sx_ready | output | 1 | Simplex byte consumed this cycle |
| ctl_data | input | 8 | Control channel byte |
| ctl_valid | input | 1 | Control byte available |
| ctl_ready | output | 1 | Control byte consumed this cycle |
| dx_data | input | 8 | Duplex channel byte |
| dx_valid | input | 1 | Duplex byte available |
| dx_ready | output | 1 | Duplex byte consumed this cycle |
| crc_fast_in | input | 8 | CRC value for the fast path |
| crc_intl_in | input | 8 | CRC value for the interleaved path |
| ind_in | input | 24 | Indicator bytes for frames 1, 34, 35 |
| fast_data | output | 8 | Fast-path byte |
| fast_vld | output | 1 | Fast-path byte valid |
| fast_sof | output | 1 | Fast-path start of frame |
| fast_sosf | output | 1 | Fast-path start of superframe |
| intl_data | output | 8 | Interleaved-path byte |
| intl_vld | output | 1 | Interleaved-path byte valid |
| intl_sof | output | 1 | Interleaved-path start of frame |
| intl_sosf | output | 1 | Interleaved-path start of superframe |

## Verification
On every cycle, the embedded properties check several things: silence before start-up, the rule that ready implies valid, the fast stream staying inside the interleaved stream, superframe markers matching on both paths, the counter range and wrap, a frozen position during a stall, and the CRC appearing in the frame-0 overhead slot. Only the bench's scenarios can show the rest, because it compares every byte against a model of the frame layout. That covers the exact byte order within each frame, control bytes alternating with idle fills, payload-free sync frames, and indicator placement. It also covers capture of new CRC and indicator values at superframe boundaries while those inputs change, and the cycle-exact stall pattern under random channel availability.

// File: rtl/sf_pkg.sv
package sf_pkg;

   typedef logic [7:0] byte_t;

   // number of frames whose overhead byte carries indicator bits
   localparam int NUM_IND = 3;

   // frame index that carries indicator byte k
   function automatic int ind_frame(input int k, input int frames);
      int r;
      if (k == 0)      r = 1;
      else if (k == 1) r = frames / 2;
      else             r = frames / 2 + 1;
      return r;
   endfunction

endpackage

// File: rtl/sf_slot_counter.sv
module sf_slot_counter #(
   parameter int FRAME_LEN = 52,
   parameter int FRAMES    = 68,
   parameter int POS_W     = 6,
   parameter int FRM_W     = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [POS_W-1:0] pos,
   output logic [FRM_W-1:0] frame,
   output logic             is_sync,
   output logic             sf_end
);

   localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_LEN - 1);
   localparam logic [FRM_W-1:0] FRM_SYNC = FRM_W'(FRAMES);

   if (FRAME_LEN < 2) begin : g_bad_len
      $error("sf_slot_counter: FRAME_LEN too small");
   end
   if ((1 << POS_W) <= FRAME_LEN) begin : g_bad_posw
      $error("sf_slot_counter: POS_W too narrow");
   end
   if ((1 << FRM_W) <= FRAMES) begin : g_bad_frmw
      $error("sf_slot_counter: FRM_W too narrow");
   end

   logic pos_wrap;

   assign pos_wrap = (pos == POS_LAST);
   assign is_sync  = (frame == FRM_SYNC);
   assign sf_end   = is_sync && pos_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos   <= '0;
         frame <= '0;
      end else if (adv) begin
         if (pos_wrap) begin
            pos   <= '0;
            frame <= is_sync ? '0 : frame + 1'b1;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end

   // R5
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos <= POS_LAST) && (frame <= FRM_SYNC));

   // R5
   sf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && sf_end) |=> (frame == '0) && (pos == '0));

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(pos) && $stable(frame));

endmodule

// File: rtl/sf_ovh_bank.sv
module sf_ovh_bank
   import sf_pkg::*;
#(
   parameter int          FRAMES    = 68,
   parameter int          FRM_W     = 7,
   parameter logic [7:0]  SYNC_BYTE = 8'hA5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  byte_t                crc_fast_in,
   input  byte_t                crc_intl_in,
   input  logic [NUM_IND*8-1:0] ind_in,
   input  logic [FRM_W-1:0]     frame,
   output byte_t                ovh_fast,
   output byte_t                ovh_intl,
   output byte_t                crc_fast_q,
   output byte_t                crc_intl_q
);

   if (FRAMES < 4 || (FRAMES % 2) != 0) begin : g_bad_frames
      $error("sf_ovh_bank: FRAMES must be even and at least 4");
   end

   logic [NUM_IND*8-1:0] ind_q;
   logic [NUM_IND-1:0]   hit;
   byte_t                ind_sel;
   logic                 crc_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_fast_q <= '0;
         crc_intl_q <= '0;
         ind_q      <= '0;
      end else if (load) begin
         crc_fast_q <= crc_fast_in;
         crc_intl_q <= crc_intl_in;
         ind_q      <= ind_in;
      end
   end

   for (genvar k = 0; k < NUM_IND; k++) begin : g_ind_slot
      assign hit[k] = (frame == FRM_W'(ind_frame(k, FRAMES)));
   end

   always_comb begin
      ind_sel = '0;
      for (int k = 0; k < NUM_IND; k++) begin
         if (hit[k]) ind_sel = ind_sel | ind_q[k*8 +: 8];
      end
   end

   assign crc_slot = (frame == '0);
   assign ovh_fast = crc_slot ? crc_fast_q : (|hit ? ind_sel : SYNC_BYTE);
   assign ovh_intl = crc_slot ? crc_intl_q : (|hit ? ind_sel : SYNC_BYTE);

   // R7
   ind_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |hit |-> (ovh_fast == ovh_intl) && !crc_slot);

endmodule

// File: rtl/sf_path_mux.sv
module sf_path_mux
   import sf_pkg::*;
#(
   parameter int          FRAME_LEN = 52,
   parameter int          POS_W     = 6,
   parameter int          PAY_LEN   = 48,
   parameter bit          CTRL_EN   = 1'b1,
   parameter int          TAIL_LEN  = 2,
   parameter logic [7:0]  IDLE_BYTE = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [POS_W-1:0] pos,
   input  logic             is_sync,
   input  logic             frame_even,
   input  logic             frame_zero,
   input  byte_t            ovh,
   input  byte_t            pay_data,
   input  byte_t            ctl_data,
   output logic             need_pay,
   output logic             need_ctl,
   output byte_t            o_data,
   output logic             o_vld,
   output logic             o_sof,
   output logic             o_sosf
);

   localparam int PATH_LEN = 1 + PAY_LEN + (CTRL_EN ? 1 : 0) + TAIL_LEN;

   if (PAY_LEN < 1) begin : g_bad_pay
      $error("sf_path_mux: PAY_LEN must be at least 1");
   end
   if (PATH_LEN > FRAME_LEN) begin : g_bad_path
      $error("sf_path_mux: path frame longer than frame slot");
   end

   logic  active;
   logic  pay_pos;
   logic  ctl_pos;
   byte_t nxt_byte;

   assign active  = (pos < POS_W'(PATH_LEN));
   assign pay_pos = (pos >= POS_W'(1)) && (pos <= POS_W'(PAY_LEN));
   assign need_pay = pay_pos && !is_sync;

   if (CTRL_EN) begin : g_ctl
      assign ctl_pos  = (pos == POS_W'(PAY_LEN + 1));
      assign need_ctl = ctl_pos && frame_even && !is_sync;
   end else begin : g_noctl
      logic unused_ctl;
      assign unused_ctl = ^{ctl_data, frame_even};
      assign ctl_pos    = 1'b0;
      assign need_ctl   = 1'b0;
   end

   always_comb begin
      if (pos == '0)     nxt_byte = ovh;
      else if (need_pay) nxt_byte = pay_data;
      else if (need_ctl) nxt_byte = ctl_data;
      else               nxt_byte = IDLE_BYTE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_data <= '0;
         o_vld  <= 1'b0;
         o_sof  <= 1'b0;
         o_sosf <= 1'b0;
      end else begin
         o_vld  <= adv && active;
         o_sof  <= adv && (pos == '0);
         o_sosf <= adv && (pos == '0) && frame_zero;
         if (adv && active) o_data <= nxt_byte;
      end
   end

   // R9
   sosf_in_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_sosf |-> o_sof);

   // R9
   sof_has_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_sof |-> o_vld);

   // R5
   sync_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_sync |-> !need_pay && !need_ctl);

endmodule

// File: rtl/sf_framer.sv
module sf_framer
   import sf_pkg::*;
#(
   parameter int          SX_BYTES  = 48,
   parameter int          DX_BYTES  = 5,
   parameter int          FRAMES    = 68,
   parameter int          INTL_TAIL = 2,
   parameter int          FAST_TAIL = 1,
   parameter logic [7:0]  SYNC_BYTE = 8'hA5,
   parameter logic [7:0]  IDLE_BYTE = 8'h00
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [7:0]           sx_data,
   input  logic                 sx_valid,
   output logic                 sx_ready,
   input  logic [7:0]           ctl_data,
   input  logic                 ctl_valid,
   output logic                 ctl_ready,
   input  logic [7:0]           dx_data,
   input  logic                 dx_valid,
   output logic                 dx_ready,
   input  logic [7:0]           crc_fast_in,
   input  logic [7:0]           crc_intl_in,
   input  logic [NUM_IND*8-1:0] ind_in,
   output logic [7:0]           fast_data,
   output logic                 fast_vld,
   output logic                 fast_sof,
   output logic                 fast_sosf,
   output logic [7:0]           intl_data,
   output logic                 intl_vld,
   output logic                 intl_sof,
   output logic                 intl_sosf
);

   localparam int INTL_LEN  = 1 + SX_BYTES + 1 + INTL_TAIL;
   localparam int FAST_LEN  = 1 + DX_BYTES + FAST_TAIL;
   localparam int FRAME_LEN = INTL_LEN;
   localparam int POS_W     = $clog2(FRAME_LEN + 1);
   localparam int FRM_W     = $clog2(FRAMES + 2);

   if (FAST_LEN > INTL_LEN) begin : g_bad_fast
      $error("sf_framer: fast frame must fit inside the frame slot");
   end
   if (SX_BYTES < 1 || DX_BYTES < 1) begin : g_bad_pay
      $error("sf_framer: payload sizes must be positive");
   end

   logic             started_q;
   logic             adv;
   logic [POS_W-1:0] pos;
   logic [FRM_W-1:0] frame;
   logic             is_sync;
   logic             sf_end;
   logic             need_sx;
   logic             need_ctl;
   logic             need_dx;
   logic             fast_need_ctl_unused;
   byte_t            ovh_fast;
   byte_t            ovh_intl;
   byte_t            crc_fast_q;
   byte_t            crc_intl_q;

   // ---------------- start-up gate and shared advance ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               started_q <= 1'b0;
      else if (sx_valid && ctl_valid && dx_valid) started_q <= 1'b1;
   end

   assign adv = started_q
             && (!need_sx  || sx_valid)
             && (!need_ctl || ctl_valid)
             && (!need_dx  || dx_valid);

   assign sx_ready  = adv && need_sx;
   assign ctl_ready = adv && need_ctl;
   assign dx_ready  = adv && need_dx;

   // ---------------- slot counter ----------------
   sf_slot_counter #(
      .FRAME_LEN (FRAME_LEN),
      .FRAMES    (FRAMES),
      .POS_W     (POS_W),
      .FRM_W     (FRM_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .pos     (pos),
      .frame   (frame),
      .is_sync (is_sync),
      .sf_end  (sf_end)
   );

   // ---------------- overhead bank ----------------
   sf_ovh_bank #(
      .FRAMES    (FRAMES),
      .FRM_W     (FRM_W),
      .SYNC_BYTE (SYNC_BYTE)
   ) u_ovh (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (adv && sf_end),
      .crc_fast_in (crc_fast_in),
      .crc_intl_in (crc_intl_in),
      .ind_in      (ind_in),
      .frame       (frame),
      .ovh_fast    (ovh_fast),
      .ovh_intl    (ovh_intl),
      .crc_fast_q  (crc_fast_q),
      .crc_intl_q  (crc_intl_q)
   );

   // ---------------- interleaved path ----------------
   sf_path_mux #(
      .FRAME_LEN (FRAME_LEN),
      .POS_W     (POS_W),
      .PAY_LEN   (SX_BYTES),
      .CTRL_EN   (1'b1),
      .TAIL_LEN  (INTL_TAIL),
      .IDLE_BYTE (IDLE_BYTE)
   ) u_intl (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (adv),
      .pos        (pos),
      .is_sync    (is_sync),
      .frame_even (~frame[0]),
      .frame_zero (frame == '0),
      .ovh        (ovh_intl),
      .pay_data   (sx_data),
      .ctl_data   (ctl_data),
      .need_pay   (need_sx),
      .need_ctl   (need_ctl),
      .o_data     (intl_data),
      .o_vld      (intl_vld),
      .o_sof      (intl_sof),
      .o_sosf     (intl_sosf)
   );

   // ---------------- fast path ----------------
   sf_path_mux #(
      .FRAME_LEN (FRAME_LEN),
      .POS_W     (POS_W),
      .PAY_LEN   (DX_BYTES),
      .CTRL_EN   (1'b0),
      .TAIL_LEN  (FAST_TAIL),
      .IDLE_BYTE (IDLE_BYTE)
   ) u_fast (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (adv),
      .pos        (pos),
      .is_sync    (is_sync),
      .frame_even (~frame[0]),
      .frame_zero (frame == '0),
      .ovh        (ovh_fast),
      .pay_data   (dx_data),
      .ctl_data   (8'h00),
      .need_pay   (need_dx),
      .need_ctl   (fast_need_ctl_unused),
      .o_data     (fast_data),
      .o_vld      (fast_vld),
      .o_sof      (fast_sof),
      .o_sosf     (fast_sosf)
   );

   // R1
   quiet_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !started_q |=> !intl_vld && !fast_vld);

   // R4
   fast_inside_intl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fast_vld |-> intl_vld);

   // R9
   sosf_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fast_sosf == intl_sosf);

   // R8
   sx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sx_ready |-> sx_valid);

   // R8
   ctl_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_ready |-> ctl_valid);

   // R8
   dx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dx_ready |-> dx_valid);

   // R6
   crc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intl_sosf |-> (intl_data == crc_intl_q) && (fast_data == crc_fast_q));

endmodule

// File: tb/tb_sf_framer.sv
module tb_sf_framer;

   localparam int SXB   = 48;
   localparam int DXB   = 5;
   localparam int NFRM  = 68;
   localparam int ILEN  = 52;
   localparam int FLEN  = 7;
   localparam int CTLP  = SXB + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sx_data = '0, ctl_data = '0, dx_data = '0;
   logic        sx_valid = 1'b0, ctl_valid = 1'b0, dx_valid = 1'b0;
   logic        sx_ready, ctl_ready, dx_ready;
   logic [7:0]  crc_fast_in = '0, crc_intl_in = '0;
   logic [23:0] ind_in = '0;
   logic [7:0]  fast_data, intl_data;
   logic        fast_vld, fast_sof, fast_sosf;
   logic        intl_vld, intl_sof, intl_sosf;

   always #5 clk = ~clk;

   sf_framer dut (
      .clk(clk), .rst_n(rst_n),
      .sx_data(sx_data), .sx_valid(sx_valid), .sx_ready(sx_ready),
      .ctl_data(ctl_data), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
      .dx_data(dx_data), .dx_valid(dx_valid), .dx_ready(dx_ready),
      .crc_fast_in(crc_fast_in), .crc_intl_in(crc_intl_in), .ind_in(ind_in),
      .fast_data(fast_data), .fast_vld(fast_vld), .fast_sof(fast_sof),
      .fast_sosf(fast_sosf),
      .intl_data(intl_data), .intl_vld(intl_vld), .intl_sof(intl_sof),
      .intl_sosf(intl_sosf)
   );

   int nchk = 0;
   int nfail = 0;

   // reference model state
   int   ef = 0, ep = 0, sf_done = 0;
   int   sx_i = 0, ctl_i = 0, dx_i = 0;
   bit   started_m = 0, pend = 0;
   logic [7:0]  m_crcf = '0, m_crci = '0;
   logic [23:0] m_ind = '0;
   bit          e_vld, e_fvld, e_sof, e_sosf;
   logic [7:0]  e_idata, e_fdata;

   function automatic logic [7:0] sx_byte(input int i);
      return 8'((i * 5 + 17) & 255);
   endfunction
   function automatic logic [7:0] ctl_byte(input int i);
      return 8'((i * 11 + 3) & 255);
   endfunction
   function automatic logic [7:0] dx_byte(input int i);
      return 8'((i * 13 + 101) & 255);
   endfunction

   function automatic logic [7:0] ovh_ref(input int f, input logic [7:0] crc,
                                          input logic [23:0] ind);
      if (f == 0)             return crc;
      if (f == 1)             return ind[7:0];
      if (f == NFRM / 2)      return ind[15:8];
      if (f == NFRM / 2 + 1)  return ind[23:16];
      return 8'hA5;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h (frame %0d pos %0d)", req, act, exp, ef, ep);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   // mode 0: all valid, 1: duplex withheld, 2: random availability
   task automatic cycle(input int mode);
      bit nsx, nctl, ndx, sync, adv;
      @(negedge clk);
      if (pend) begin
         chk(intl_vld == e_vld, "R8 intl_vld", intl_vld, e_vld);
         chk(fast_vld == e_fvld, "R4 fast_vld", fast_vld, e_fvld);
         if (e_vld) begin
            chk(intl_data == e_idata, "R2 intl_data", intl_data, e_idata);
            chk(intl_sof == e_sof, "R9 intl_sof", intl_sof, e_sof);
            chk(intl_sosf == e_sosf, "R9 intl_sosf", intl_sosf, e_sosf);
         end
         if (e_fvld) begin
            chk(fast_data == e_fdata, "R4 fast_data", fast_data, e_fdata);
            chk(fast_sof == e_sof, "R9 fast_sof", fast_sof, e_sof);
            chk(fast_sosf == e_sosf, "R9 fast_sosf", fast_sosf, e_sosf);
         end
      end
      if (mode == 0) begin
         sx_valid = 1; ctl_valid = 1; dx_valid = 1;
      end else if (mode == 1) begin
         sx_valid = 1; ctl_valid = 1; dx_valid = 0;
      end else begin
         sx_valid  = ($urandom % 4) != 0;
         ctl_valid = ($urandom % 3) != 0;
         dx_valid  = ($urandom % 4) != 0;
      end
      if (ef >= 8 && ef <= 12) begin
         crc_fast_in = 8'($urandom);
         crc_intl_in = 8'($urandom);
         ind_in      = 24'($urandom);
      end
      sx_data  = sx_byte(sx_i);
      ctl_data = ctl_byte(ctl_i);
      dx_data  = dx_byte(dx_i);
      #1;
      sync = (ef == NFRM);
      nsx  = !sync && ep >= 1 && ep <= SXB;
      nctl = !sync && ep == CTLP && (ef % 2 == 0);
      ndx  = !sync && ep >= 1 && ep <= DXB;
      adv  = started_m && (!nsx || sx_valid) && (!nctl || ctl_valid) && (!ndx || dx_valid);
      chk(sx_ready == (adv && nsx), "R8 sx_ready", sx_ready, adv && nsx);
      chk(ctl_ready == (adv && nctl), "R3 ctl_ready", ctl_ready, adv && nctl);
      chk(dx_ready == (adv && ndx), "R8 dx_ready", dx_ready, adv && ndx);
      e_vld  = adv;
      e_fvld = adv && ep < FLEN;
      e_sof  = ep == 0;
      e_sosf = ep == 0 && ef == 0;
      // interleaved byte (R2, R3, R5, R6, R7)
      if (ep == 0)   e_idata = ovh_ref(ef, m_crci, m_ind);
      else if (nsx)  e_idata = sx_data;
      else if (nctl) e_idata = ctl_data;
      else           e_idata = 8'h00;
      // fast byte (R4)
      if (ep == 0)   e_fdata = ovh_ref(ef, m_crcf, m_ind);
      else if (ndx)  e_fdata = dx_data;
      else           e_fdata = 8'h00;
      pend = 1;
      if (sx_valid && ctl_valid && dx_valid) started_m = 1;
      if (adv) begin
         if (nsx)  sx_i++;
         if (nctl) ctl_i++;
         if (ndx)  dx_i++;
         if (ef == NFRM && ep == ILEN - 1) begin
            m_crcf = crc_fast_in; m_crci = crc_intl_in; m_ind = ind_in;
         end
         if (ep == ILEN - 1) begin
            ep = 0;
            if (ef == NFRM) begin ef = 0; sf_done++; end
            else ef++;
         end else ep++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", sf_done, 4);
      summary();
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(intl_vld == 0 && fast_vld == 0, "R1 reset vld", {intl_vld, fast_vld}, 0);
      chk({sx_ready, ctl_ready, dx_ready} == 3'b000, "R1 reset ready",
          {sx_ready, ctl_ready, dx_ready}, 0);
      chk(intl_sosf == 0 && fast_sosf == 0, "R9 reset sosf", {intl_sosf, fast_sosf}, 0);
      rst_n = 1;
      // R1: one channel withheld, nothing may start
      for (int i = 0; i < 25; i++) cycle(1);
      @(negedge clk);
      chk(intl_vld == 0 && fast_vld == 0, "R1 no start", {intl_vld, fast_vld}, 0);
      chk(sx_i == 0 && ctl_i == 0 && dx_i == 0, "R1 nothing consumed", sx_i + ctl_i + dx_i, 0);
      // directed: uninterrupted first superframe (R6 zero CRC, R5 sync frame)
      while (sf_done < 1) cycle(0);
      // random availability over several superframes (R3, R6, R7, R8)
      while (sf_done < 4) cycle(2);
      cycle(0);
      chk(sf_done == 4, "R5 superframes completed", sf_done, 4);
      summary();
      $finish;
   end

endmodule